// File: doc/BRIEF.md
# Square-Wave FM Transmitter Core

This block turns a stream of baseband samples into a frequency-modulated, two-level RF signal. Each accepted sample becomes the phase step of a 16-bit wrapping phase accumulator. The accumulator's top bit is a square wave whose frequency follows the sample, so the accumulator serves as the voltage-controlled oscillator.

That oscillator square wave is up-converted by a single XNOR against a two-level local oscillator. On hard-limited signals the XNOR is the product of two ±1 waveforms. The mixed bit is registered and drives a complementary antenna pair. A probe pin shows either the mixed RF bit or the LO divided by four.

An optional right shift of each sample reduces the frequency deviation. When the scaling stage is built in, it adds one register stage between a sample and its use. The LO is either an internal toggle-every-clock wave or a registered copy of an external reference pin.

Top module: `fm_xnor_tx`

## Requirements
- R1: A sample accepted with `smp_valid_i` high at a rising edge is zero-extended to 16 bits and right-shifted by `dev_shift_i`. It is held in a staging register at that edge, loaded as the phase step at the next edge, and added to the accumulator from the edge after that.
- R2: While `smp_valid_i` is low, the phase step keeps its previous value, whatever is on `smp_data_i` or `dev_shift_i`.
- R3: The accumulator adds the phase step at every rising edge, modulo 2^16. The oscillator bit is its most significant bit, so its frequency is step × f_clk / 65536.
- R4: At each edge the mixed bit is registered as XNOR(oscillator bit, LO bit), using the values before that edge. `ant_p_o` shows this mixed bit.
- R5: `ant_n_o` is always the inverse of `ant_p_o`.
- R6: The probe is selected by `probe_sel_i`. With 0 it shows `ant_p_o`. With 1 it shows bit 2 of a 3-bit counter that advances at each edge where the LO bit differs from its value one clock earlier, which is the LO divided by four.
- R7: The LO is selected by `lo_sel_i`. With 0 it is an internal bit that is 0 in reset and inverts at every edge. With 1 it is `ext_lo_i` registered once.
- R8: A low `rst_n` at a rising edge clears the staging register, the phase step, the accumulator, the internal LO, the external LO register, the LO history, the divide counter and the mixed bit. After such an edge, `ant_p_o`=0, `ant_n_o`=1 and the probe is 0.
- R9: `dev_shift_i` is sampled together with the sample. A shift of 0 to 3 divides the sample by 1, 2, 4 or 8 and drops the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the internal LO reference |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_data_i | input | 10 | Baseband sample |
| smp_valid_i | input | 1 | Sample strobe, one cycle per sample |
| dev_shift_i | input | 2 | Deviation right-shift amount |
| lo_sel_i | input | 1 | 0 selects the internal LO, 1 selects the external LO |
| ext_lo_i | input | 1 | External LO reference level |
| probe_sel_i | input | 1 | 0 selects the RF bit on the probe, 1 selects LO/4 |
| ant_p_o | output | 1 | Antenna output, true side |
| ant_n_o | output | 1 | Antenna output, complement side |
| probe_o | output | 1 | Probe output |

## Verification
A sample strobed at edge k changes the phase step at edge k+1 and first moves the accumulator at edge k+2. The antenna pins reflect an accumulator or LO change one edge later still. The probe follows its select input combinationally.

The bench drives inputs one nanosecond after a rising edge and compares every output at the following falling edge. The expected values come from a cycle model built from these delays. Two long runs at a held LO count oscillator periods and compare the count with step × cycles / 65536, which checks the frequency itself without depending on the model.

// File: rtl/fmx_pkg.sv
// Package: shared types of the square-wave FM transmitter.
// Assumes: none; pure type definitions.
package fmx_pkg;
    typedef enum logic {LO_INTERNAL = 1'b0, LO_EXTERNAL = 1'b1} lo_src_e;
    typedef enum logic {PROBE_RF = 1'b0, PROBE_LODIV = 1'b1} probe_src_e;
endpackage

// File: rtl/fmx_sample_loader.sv
// Module: scales each accepted sample and loads it as the NCO phase step.
// Assumes: smp_valid_i is a one-cycle strobe; rst_n is synchronous, active low.
module fmx_sample_loader #(
    parameter int SAMPLE_W = 10,
    parameter int PHASE_W  = 16,
    parameter int SHIFT_W  = 2,
    parameter bit SCALE_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic                smp_valid_i,
    input  logic [SHIFT_W-1:0]  dev_shift_i,
    output logic [PHASE_W-1:0]  step_o
);
    logic [PHASE_W-1:0] scaled;
    logic [PHASE_W-1:0] step_q;

    // Zero-extend the sample to phase width and apply the deviation shift.
    always_comb scaled = PHASE_W'(smp_data_i) >> dev_shift_i;

    generate
        if (SCALE_EN) begin : g_staged
            logic [PHASE_W-1:0] stage_q;
            logic               stage_v_q;

            // Hold the scaled sample for one cycle before the load.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q   <= '0;
                    stage_v_q <= 1'b0;
                end else begin
                    stage_q   <= scaled;
                    stage_v_q <= smp_valid_i;
                end
            end

            // Load the staged value into the step register.
            always_ff @(posedge clk) begin
                if (!rst_n)         step_q <= '0;
                else if (stage_v_q) step_q <= stage_q;
            end

            assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
                stage_v_q |=> step_q == $past(stage_q));
            assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !stage_v_q |=> $stable(step_q));
        end else begin : g_direct
            // Load the scaled sample straight into the step register.
            always_ff @(posedge clk) begin
                if (!rst_n)           step_q <= '0;
                else if (smp_valid_i) step_q <= scaled;
            end

            assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !smp_valid_i |=> $stable(step_q));
        end
    endgenerate

    assign step_o = step_q;
endmodule

// File: rtl/fmx_nco.sv
// Module: wrapping phase accumulator; its top bit is the oscillator square wave.
// Assumes: step_i is a registered value; rst_n is synchronous, active low.
module fmx_nco #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] step_i,
    output logic               osc_o
);
    logic [PHASE_W-1:0] acc_q;

    // Add the phase step every clock; overflow wraps modulo 2^PHASE_W.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + step_i;
    end

    assign osc_o = acc_q[PHASE_W-1];

    assert_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0) |=> $stable(osc_o));
endmodule

// File: rtl/fmx_lo_mixer.sv
// Module: LO source, XNOR mixer, complementary antenna drive and probe mux.
// Assumes: ext_lo_i is synchronous to clk or tolerates one sampling register.
module fmx_lo_mixer
    import fmx_pkg::*;
#(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    input  logic lo_sel_i,
    input  logic ext_lo_i,
    input  logic probe_sel_i,
    output logic ant_p_o,
    output logic ant_n_o,
    output logic probe_o
);
    localparam int CNT_W = DIV_LOG2 + 1;

    logic             lo_int_q, lo_ext_q, lo_prev_q, rf_q;
    logic             lo;
    logic [CNT_W-1:0] div_q;
    lo_src_e          lo_src;
    probe_src_e       probe_src;

    // Decode the selects into named sources and pick the LO bit.
    always_comb begin
        lo_src    = lo_src_e'(lo_sel_i);
        probe_src = probe_src_e'(probe_sel_i);
        lo        = (lo_src == LO_EXTERNAL) ? lo_ext_q : lo_int_q;
    end

    // Internal LO toggle, external LO sampling and LO history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_int_q  <= 1'b0;
            lo_ext_q  <= 1'b0;
            lo_prev_q <= 1'b0;
        end else begin
            lo_int_q  <= ~lo_int_q;
            lo_ext_q  <= ext_lo_i;
            lo_prev_q <= lo;
        end
    end

    // Count LO transitions; the top counter bit is LO divided by four.
    always_ff @(posedge clk) begin
        if (!rst_n)               div_q <= '0;
        else if (lo != lo_prev_q) div_q <= div_q + 1'b1;
    end

    // Hard-limited multiply: XNOR of oscillator and LO, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= 1'b0;
        else        rf_q <= ~(osc_i ^ lo);
    end

    assign ant_p_o = rf_q;
    assign ant_n_o = ~rf_q;
    assign probe_o = (probe_src == PROBE_LODIV) ? div_q[DIV_LOG2] : rf_q;

    assert_mix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ant_p_o == ~($past(osc_i) ^ $past(lo)));
    assert_div_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lo == lo_prev_q) |=> $stable(div_q));
    assert_lo_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lo_int_q != $past(lo_int_q));

    // Complementary pair check, sampled away from the update.
    always_comb begin
        if (rst_n) begin
            assert_compl_R5: assert (ant_p_o ^ ant_n_o);
        end
    end
endmodule

// File: rtl/fm_xnor_tx.sv
// Module: top of the square-wave FM transmitter (loader -> NCO -> XNOR mixer).
// Assumes: one clock domain; rst_n is synchronous, active low.
module fm_xnor_tx #(
    parameter int SAMPLE_W = 10,
    parameter int PHASE_W  = 16,
    parameter int SHIFT_W  = 2,
    parameter bit SCALE_EN = 1'b1,
    parameter int DIV_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_data_i,
    input  logic                smp_valid_i,
    input  logic [SHIFT_W-1:0]  dev_shift_i,
    input  logic                lo_sel_i,
    input  logic                ext_lo_i,
    input  logic                probe_sel_i,
    output logic                ant_p_o,
    output logic                ant_n_o,
    output logic                probe_o
);
    logic [PHASE_W-1:0] step;
    logic               osc;

    fmx_sample_loader #(
        .SAMPLE_W(SAMPLE_W), .PHASE_W(PHASE_W),
        .SHIFT_W(SHIFT_W),   .SCALE_EN(SCALE_EN)
    ) u_loader (
        .clk(clk), .rst_n(rst_n), .smp_data_i(smp_data_i),
        .smp_valid_i(smp_valid_i), .dev_shift_i(dev_shift_i), .step_o(step)
    );

    fmx_nco #(.PHASE_W(PHASE_W)) u_nco (
        .clk(clk), .rst_n(rst_n), .step_i(step), .osc_o(osc)
    );

    fmx_lo_mixer #(.DIV_LOG2(DIV_LOG2)) u_mix (
        .clk(clk), .rst_n(rst_n), .osc_i(osc), .lo_sel_i(lo_sel_i),
        .ext_lo_i(ext_lo_i), .probe_sel_i(probe_sel_i),
        .ant_p_o(ant_p_o), .ant_n_o(ant_n_o), .probe_o(probe_o)
    );
endmodule

// File: tb/fm_xnor_tx_tb.sv
`timescale 1ns/1ps
module fm_xnor_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] smp = '0;
    logic       vld = 1'b0;
    logic [1:0] shf = '0;
    logic       lsel = 1'b0, elo = 1'b0, psel = 1'b0;
    logic       ant_p, ant_n, probe;
    logic       chk_en = 1'b0;
    logic       done = 1'b0;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    fm_xnor_tx u_dut (
        .clk(clk), .rst_n(rst_n), .smp_data_i(smp), .smp_valid_i(vld),
        .dev_shift_i(shf), .lo_sel_i(lsel), .ext_lo_i(elo), .probe_sel_i(psel),
        .ant_p_o(ant_p), .ant_n_o(ant_n), .probe_o(probe)
    );

    // Cycle model built from the requirement delays.
    logic [15:0] m_st, m_step, m_acc;
    logic        m_stv, m_li, m_le, m_prev, m_rf;
    logic [2:0]  m_cnt;
    logic        m_lo;
    always_comb m_lo = lsel ? m_le : m_li;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= '0; m_stv <= 1'b0; m_step <= '0; m_acc <= '0;
            m_li <= 1'b0; m_le <= 1'b0; m_prev <= 1'b0; m_cnt <= '0; m_rf <= 1'b0;
        end else begin
            m_st   <= {6'd0, smp} / (16'd1 << shf);
            m_stv  <= vld;
            if (m_stv) m_step <= m_st;
            m_acc  <= m_acc + m_step;
            m_li   <= ~m_li;
            m_le   <= elo;
            m_prev <= m_lo;
            if (m_lo != m_prev) m_cnt <= m_cnt + 3'd1;
            m_rf   <= ~(m_acc[15] ^ m_lo);
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        if (chk_en) begin
            check("R1 R2 R3 R4 R7 R9 ant_p", ant_p, m_rf);
            check("R5 ant_n", ant_n, ~ant_p);
            check("R6 probe", probe, psel ? m_cnt[2] : m_rf);
        end
    end

    task automatic tick(); @(posedge clk); #1; endtask

    // Hold the LO at 0 and count oscillator rising edges on ant_n.
    task automatic freq_run(input logic [9:0] s, input logic [1:0] sh, input string tag);
        int edges = 0;
        logic prv;
        longint step, lo_b, hi_b;
        lsel = 1'b1; elo = 1'b0; smp = s; shf = sh; vld = 1'b1;
        tick(); vld = 1'b0; smp = ~s; shf = ~sh;
        repeat (4) tick();
        @(negedge clk); prv = ant_n;
        for (int i = 0; i < 16384; i++) begin
            @(negedge clk);
            if (!prv && ant_n) edges++;
            prv = ant_n;
        end
        step = longint'(s) >> sh;
        lo_b = (step * 16384) / 65536 - 1;
        hi_b = (step * 16384) / 65536 + 1;
        n_chk++;
        if (edges < lo_b || edges > hi_b) begin
            n_bad++;
            $display("FAIL %s edges actual=%0d expected=%0d..%0d", tag, edges, lo_b, hi_b);
        end
        tick();
    endtask

    initial begin
        repeat (3) tick();
        // R8: reset state, checked before releasing reset.
        @(negedge clk);
        check("R8 ant_p reset", ant_p, 1'b0);
        check("R8 ant_n reset", ant_n, 1'b1);
        psel = 1'b1; #1;
        check("R8 probe div reset", probe, 1'b0);
        psel = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        chk_en = 1'b1;
        // Sweep every shift and every sample value; vary the LO and probe selects.
        for (int sh = 0; sh < 4; sh++) begin
            for (int s = 0; s < 1024; s++) begin
                smp = 10'(s); shf = 2'(sh); vld = 1'b1;
                lsel = s[0]; psel = s[1];
                elo = s[2] ^ s[4];
                tick();
                vld = 1'b0; smp = ~10'(s); shf = ~2'(sh);
                for (int c = 0; c < 5; c++) begin
                    elo = ~elo ^ c[1];
                    tick();
                end
            end
        end
        // R8: reset in mid-run.
        rst_n = 1'b0; tick();
        chk_en = 1'b0;
        @(negedge clk);
        check("R8 ant_p mid reset", ant_p, 1'b0);
        check("R8 ant_n mid reset", ant_n, 1'b1);
        tick(); rst_n = 1'b1; chk_en = 1'b1;
        // R3 and R9: frequency equals step*cycles/65536.
        freq_run(10'd1023, 2'd0, "R3 freq");
        freq_run(10'd1020, 2'd2, "R9 freq shift");
        chk_en = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule